// File: doc/BRIEF.md
# Coprocessor Command and Status Controller

This block sits between a register-mapped host port and a coprocessor's engine. Software writes an 8-bit command code to launch one of three operations: program execution, data-memory wipe or instruction-memory wipe. The controller then tracks the operation in progress as an 8-bit status code and pulses a launch strobe to the engine. When the operation ends, the controller returns to idle and latches a done interrupt.

The engine reports back through single-cycle strobes: operation finished, instruction retired, five software error lines and six fatal error lines. The controller handles these events in three ways:
- Software errors stop the operation, are recorded, and produce one recoverable alert pulse.
- Fatal errors lock the controller until reset and hold the fatal alert high.
- A saturating counter tallies retired instructions during execution and restarts with each accepted command.

The engine also gets the execution start byte address, which software loads through a write-only register. All register reads return registered data one cycle after the read address is presented.

Top module: `cop_ctrl`

## Requirements
- R1: After reset: status is 0x00, the error, fatal-cause and counter registers read 0, and the interrupt and both alerts are low.
- R2: In status 0x00, writing command 0x01, 0x02 or 0x03 to the command register (offset 0x00) sets the status to the same code at the next clock edge. go_o is high for exactly that one cycle.
- R3: A command write with any other code leaves the status at 0x00 and does not raise go_o.
- R4: A command write while the status is not 0x00 has no effect on the status.
- R5: In a busy state (0x01 to 0x03), op_done_i returns the status to 0x00 at the next edge.
  - irq_done_o rises one cycle after that and stays high.
  - It clears only when 1 is written to bit 0 of the interrupt register (offset 0x18). Writing 0 leaves it set.
- R6: A nonzero sw_err_i in a busy state stops the operation:
  - The status returns to 0x00.
  - The error register (offset 0x08) has the same bits ORed into bits 4:0. The bits are, from bit 0 upward: bad data address, bad instruction address, call stack, illegal instruction and loop.
  - alert_recov_o is high for exactly one cycle, in the cycle the status becomes 0x00.
  - The done interrupt follows as in R5.
- R7: A nonzero fatal_err_i in any state has the following effects:
  - The status becomes 0xFF, and alert_fatal_o stays high until reset.
  - The error bits are set at bits 21:16, and the fatal-cause register (offset 0x10) at bits 5:0.
  - The fatal bits are, from the lowest upward: imem integrity, dmem integrity, register integrity, bus integrity, illegal bus access and lifecycle escalation.
  - Afterwards, commands and op_done_i have no effect.
- R8: The instruction counter (offset 0x14) increments on each cycle with insn_retire_i high while the status is 0x01.
  - It does not count in a cycle with any error input high, nor in other states.
  - It saturates at its all-ones value.
- R9: An accepted command clears the error register and the counter. The fatal-cause register is cleared only by reset.
- R10: A write to the start-address register (offset 0x0C) appears on start_addr_o at the next edge.
- R11: Reads are registered. The command and start-address offsets read 0, the status register is at offset 0x04, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | ADDR_W | Write byte offset |
| reg_wdata_i | input | DATA_W | Write data |
| reg_raddr_i | input | ADDR_W | Read byte offset |
| reg_rdata_o | output | DATA_W | Registered read data |
| op_done_i | input | 1 | Engine finished the current operation |
| insn_retire_i | input | 1 | Engine retired one instruction |
| sw_err_i | input | 5 | Software error strobes |
| fatal_err_i | input | 6 | Fatal error strobes |
| status_o | output | 8 | Current status code |
| go_o | output | 1 | One-cycle launch strobe to the engine |
| start_addr_o | output | DATA_W | Execution start byte address |
| irq_done_o | output | 1 | Sticky done interrupt |
| alert_recov_o | output | 1 | Recoverable alert pulse |
| alert_fatal_o | output | 1 | Fatal alert level |

## Verification
The command decode is driven with each legal code from idle, with illegal codes (0x00, 0x07), and with legal codes while busy and while locked. This separates the acceptance check from the code check.

Operations are ended three ways: by a plain finish, by a software error that arrives together with a retire, and by a fatal error. Each ending gives its own combination of status, alert, error-bit and interrupt timing.

The counter is driven with retires during execution, during a wipe, alongside an error, and past its saturation point. The counter width is reduced in the bench so that the ceiling can be reached.

// File: rtl/cop_ctrl_pkg.sv
`timescale 1ns/1ps
package cop_ctrl_pkg;

  typedef enum logic [7:0] {
    ST_IDLE   = 8'h00,
    ST_EXEC   = 8'h01,
    ST_WIPE_D = 8'h02,
    ST_WIPE_I = 8'h03,
    ST_LOCK   = 8'hFF
  } status_e;

  localparam int NUM_SW    = 5;
  localparam int NUM_FATAL = 6;
  localparam int FATAL_LSB = 16;

  // byte offsets of the register map
  localparam int OFF_CMD    = 'h00;
  localparam int OFF_STATUS = 'h04;
  localparam int OFF_ERR    = 'h08;
  localparam int OFF_START  = 'h0C;
  localparam int OFF_CAUSE  = 'h10;
  localparam int OFF_ICNT   = 'h14;
  localparam int OFF_INTR   = 'h18;

  function automatic logic cmd_known(input logic [7:0] code);
    return (code == 8'h01) || (code == 8'h02) || (code == 8'h03);
  endfunction

endpackage

// File: rtl/cop_ctrl_fsm.sv
`timescale 1ns/1ps
module cop_ctrl_fsm
  import cop_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_code,
  input  logic       op_done,
  input  logic       sw_err_any,
  input  logic       fatal_any,
  output status_e    status_q,
  output logic       accept,
  output logic       busy,
  output logic       go_q,
  output logic       recov_q,
  output logic       fin_q
);

  logic finish, stop_err;
  status_e status_d;

  always_comb begin
    busy     = (status_q == ST_EXEC) || (status_q == ST_WIPE_D) || (status_q == ST_WIPE_I);
    accept   = cmd_wr && (status_q == ST_IDLE) && cmd_known(cmd_code) && !fatal_any;
    finish   = busy && !fatal_any && (op_done || sw_err_any);
    stop_err = busy && !fatal_any && sw_err_any;
    status_d = status_q;
    if (fatal_any)   status_d = ST_LOCK;
    else if (accept) status_d = status_e'(cmd_code);
    else if (finish) status_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= ST_IDLE;
      go_q     <= 1'b0;
      recov_q  <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      go_q     <= accept;
      recov_q  <= stop_err;
      fin_q    <= finish;
    end
  end

endmodule

// File: rtl/cop_ctrl_errs.sv
`timescale 1ns/1ps
module cop_ctrl_errs #(
  parameter int NSW = 5,
  parameter int NFT = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           capture_sw,
  input  logic [NSW-1:0] sw_err,
  input  logic [NFT-1:0] fatal_err,
  output logic [NSW-1:0] sw_bits_q,
  output logic [NFT-1:0] fatal_bits_q,
  output logic [NFT-1:0] cause_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_bits_q    <= '0;
      fatal_bits_q <= '0;
      cause_q      <= '0;
    end else begin
      if (clear)           sw_bits_q <= '0;
      else if (capture_sw) sw_bits_q <= sw_bits_q | sw_err;
      if (clear) fatal_bits_q <= '0;
      else       fatal_bits_q <= fatal_bits_q | fatal_err;
      cause_q <= cause_q | fatal_err;
    end
  end

endmodule

// File: rtl/cop_ctrl_icnt.sv
`timescale 1ns/1ps
module cop_ctrl_icnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] cnt_q
);

  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || clear)                 cnt_q <= '0;
    else if (inc && (cnt_q != MAXV))  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/cop_ctrl.sv
`timescale 1ns/1ps
module cop_ctrl
  import cop_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_waddr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  input  logic [ADDR_W-1:0]    reg_raddr_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic                 op_done_i,
  input  logic                 insn_retire_i,
  input  logic [NUM_SW-1:0]    sw_err_i,
  input  logic [NUM_FATAL-1:0] fatal_err_i,
  output logic [7:0]           status_o,
  output logic                 go_o,
  output logic [DATA_W-1:0]    start_addr_o,
  output logic                 irq_done_o,
  output logic                 alert_recov_o,
  output logic                 alert_fatal_o
);

  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_ERR    = ADDR_W'(OFF_ERR);
  localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(OFF_START);
  localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(OFF_CAUSE);
  localparam logic [ADDR_W-1:0] A_ICNT   = ADDR_W'(OFF_ICNT);
  localparam logic [ADDR_W-1:0] A_INTR   = ADDR_W'(OFF_INTR);

  status_e                status_q;
  logic                   accept, busy, go_q, recov_q, fin_q;
  logic                   sw_any, fatal_any, cmd_wr, intr_w1c, cnt_inc;
  logic [NUM_SW-1:0]      sw_bits;
  logic [NUM_FATAL-1:0]   fatal_bits, cause;
  logic [CNT_W-1:0]       cnt_q;
  logic [DATA_W-1:0]      err_word, cause_word, cnt_word, rd_d;
  logic                   irq_q, fatal_q;
  logic [DATA_W-1:0]      start_q;

  assign sw_any    = |sw_err_i;
  assign fatal_any = |fatal_err_i;
  assign cmd_wr    = reg_wr_i && (reg_waddr_i == A_CMD);
  assign intr_w1c  = reg_wr_i && (reg_waddr_i == A_INTR) && reg_wdata_i[0];
  assign cnt_inc   = (status_q == ST_EXEC) && insn_retire_i && !sw_any && !fatal_any;

  cop_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cmd_wr     (cmd_wr),
    .cmd_code   (reg_wdata_i[7:0]),
    .op_done    (op_done_i),
    .sw_err_any (sw_any),
    .fatal_any  (fatal_any),
    .status_q   (status_q),
    .accept     (accept),
    .busy       (busy),
    .go_q       (go_q),
    .recov_q    (recov_q),
    .fin_q      (fin_q)
  );

  cop_ctrl_errs #(.NSW(NUM_SW), .NFT(NUM_FATAL)) u_errs (
    .clk          (clk),
    .rst          (rst),
    .clear        (accept),
    .capture_sw   (busy),
    .sw_err       (sw_err_i),
    .fatal_err    (fatal_err_i),
    .sw_bits_q    (sw_bits),
    .fatal_bits_q (fatal_bits),
    .cause_q      (cause)
  );

  cop_ctrl_icnt #(.W(CNT_W)) u_icnt (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .inc   (cnt_inc),
    .cnt_q (cnt_q)
  );

  always_comb begin
    err_word = '0;
    err_word[NUM_SW-1:0] = sw_bits;
    err_word[FATAL_LSB +: NUM_FATAL] = fatal_bits;
    cause_word = '0;
    cause_word[NUM_FATAL-1:0] = cause;
    cnt_word = '0;
    cnt_word[CNT_W-1:0] = cnt_q;
    case (reg_raddr_i)
      A_STATUS: rd_d = DATA_W'(status_q);
      A_ERR:    rd_d = err_word;
      A_CAUSE:  rd_d = cause_word;
      A_ICNT:   rd_d = cnt_word;
      A_INTR:   rd_d = DATA_W'(irq_q);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q       <= 1'b0;
      fatal_q     <= 1'b0;
      start_q     <= '0;
      reg_rdata_o <= '0;
    end else begin
      if (fin_q)         irq_q <= 1'b1;
      else if (intr_w1c) irq_q <= 1'b0;
      if (fatal_any) fatal_q <= 1'b1;
      if (reg_wr_i && (reg_waddr_i == A_START)) start_q <= reg_wdata_i;
      reg_rdata_o <= rd_d;
    end
  end

  assign status_o      = status_q;
  assign go_o          = go_q;
  assign start_addr_o  = start_q;
  assign irq_done_o    = irq_q;
  assign alert_recov_o = recov_q;
  assign alert_fatal_o = fatal_q;

endmodule

// File: rtl/cop_ctrl_chk.sv
`timescale 1ns/1ps
module cop_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       status_o,
  input logic             go_o,
  input logic             irq_done_o,
  input logic             alert_recov_o,
  input logic             alert_fatal_o,
  input logic             op_done_i,
  input logic [4:0]       sw_err_i,
  input logic [5:0]       fatal_err_i,
  input logic [CNT_W-1:0] cnt_q
);

  logic busy_c;
  assign busy_c = (status_o == 8'h01) || (status_o == 8'h02) || (status_o == 8'h03);

  // R7
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    alert_fatal_o |=> alert_fatal_o);

  // R7
  lock_status_chk: assert property (@(posedge clk) disable iff (rst)
    alert_fatal_o |-> (status_o == 8'hFF));

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_c && !op_done_i && (sw_err_i == 5'd0) && (fatal_err_i == 6'd0)) |=> $stable(status_o));

  // R6
  recov_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    alert_recov_o |=> !alert_recov_o);

  // R2
  go_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    go_o |-> (($past(status_o) == 8'h00) && (status_o inside {8'h01, 8'h02, 8'h03})));

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (&cnt_q) |=> ((&cnt_q) || ((cnt_q == '0) && go_o)));

  // R5
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_done_o) && !alert_fatal_o) |-> (status_o == 8'h00));

endmodule

bind cop_ctrl cop_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .status_o      (status_o),
  .go_o          (go_o),
  .irq_done_o    (irq_done_o),
  .alert_recov_o (alert_recov_o),
  .alert_fatal_o (alert_fatal_o),
  .op_done_i     (op_done_i),
  .sw_err_i      (sw_err_i),
  .fatal_err_i   (fatal_err_i),
  .cnt_q         (cnt_q)
);

// File: tb/tb_cop_ctrl.sv
`timescale 1ns/1ps
module tb_cop_ctrl;

  localparam int DW = 32;
  localparam int AW = 5;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_waddr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_raddr = '0;
  logic [DW-1:0] reg_rdata;
  logic          op_done = 1'b0;
  logic          retire = 1'b0;
  logic [4:0]    sw_err = '0;
  logic [5:0]    fatal_err = '0;
  logic [7:0]    status;
  logic          go;
  logic [DW-1:0] start_addr;
  logic          irq, a_recov, a_fatal;

  cop_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_waddr_i(reg_waddr),
    .reg_wdata_i(reg_wdata), .reg_raddr_i(reg_raddr), .reg_rdata_o(reg_rdata),
    .op_done_i(op_done), .insn_retire_i(retire), .sw_err_i(sw_err),
    .fatal_err_i(fatal_err), .status_o(status), .go_o(go),
    .start_addr_o(start_addr), .irq_done_o(irq), .alert_recov_o(a_recov),
    .alert_fatal_o(a_fatal)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  logic  rd_req = 1'b0;
  logic  seen = 1'b0;
  logic  finished = 1'b0;

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: issue a read and push its expected value
  task automatic rd(input int addr, input logic [DW-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    reg_raddr = AW'(addr);
    rd_req = 1'b1;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // monitor: compare registered read data one cycle later
  always @(posedge clk) seen <= rd_req;
  always @(negedge clk) begin
    item_t it;
    if (seen && (q.size() > 0)) begin
      it = q.pop_front();
      chk(reg_rdata, it.exp, it.tag);
    end
  end

  task automatic wr(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_waddr = AW'(addr);
    reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic strobe(input logic d, input logic r, input logic [4:0] s, input logic [5:0] f);
    @(negedge clk);
    op_done = d; retire = r; sw_err = s; fatal_err = f;
    @(negedge clk);
    op_done = 1'b0; retire = 1'b0; sw_err = '0; fatal_err = '0;
  endtask

  task automatic retire_n(input int n);
    @(negedge clk);
    retire = 1'b1;
    repeat (n) @(negedge clk);
    retire = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(status, 8'h00, "R1 status");
    chk(irq, 0, "R1 irq");
    chk(a_recov, 0, "R1 recov");
    chk(a_fatal, 0, "R1 fatal");
    rd('h04, 0, "R1 R11 status reg");
    rd('h08, 0, "R1 err reg");
    rd('h10, 0, "R1 cause reg");
    rd('h14, 0, "R1 counter");

    wr('h00, 32'h07);
    chk(status, 8'h00, "R3 code 0x07");
    chk(go, 0, "R3 no go");
    wr('h00, 32'h00);
    chk(status, 8'h00, "R3 code 0x00");

    wr('h0C, 32'h0000_1234);
    chk(start_addr, 32'h0000_1234, "R10 start addr");
    rd('h0C, 0, "R11 start reads 0");
    rd('h1C, 0, "R11 unmapped");

    wr('h00, 32'h01);
    chk(status, 8'h01, "R2 execute");
    chk(go, 1, "R2 go high");
    @(negedge clk);
    chk(go, 0, "R2 go one cycle");
    wr('h00, 32'h02);
    chk(status, 8'h01, "R4 cmd while busy");
    chk(go, 0, "R4 no go");

    retire_n(3);
    rd('h14, 3, "R8 three retires");
    rd('h04, 32'h01, "R11 status busy");

    strobe(1'b0, 1'b1, 5'b01000, 6'd0);
    chk(status, 8'h00, "R6 stop to idle");
    chk(a_recov, 1, "R6 recov alert");
    chk(irq, 0, "R5 irq not yet");
    @(negedge clk);
    chk(a_recov, 0, "R6 recov single");
    chk(irq, 1, "R5 R6 irq raised");
    rd('h08, 32'h08, "R6 err bits");
    rd('h14, 3, "R8 erroring insn not counted");
    rd('h18, 1, "R5 intr reg");
    wr('h18, 32'h1);
    chk(irq, 0, "R5 w1c clears");

    wr('h00, 32'h03);
    chk(status, 8'h03, "R2 wipe imem");
    rd('h08, 0, "R9 err cleared");
    rd('h14, 0, "R9 counter cleared");
    retire_n(2);
    rd('h14, 0, "R8 no count in wipe");
    strobe(1'b1, 1'b0, 5'd0, 6'd0);
    chk(status, 8'h00, "R5 done to idle");
    chk(irq, 0, "R5 irq delay");
    @(negedge clk);
    chk(irq, 1, "R5 irq set");
    wr('h18, 32'h0);
    chk(irq, 1, "R5 write 0 keeps");
    wr('h18, 32'h1);
    chk(irq, 0, "R5 cleared");

    wr('h00, 32'h02);
    chk(status, 8'h02, "R2 wipe dmem");
    strobe(1'b1, 1'b0, 5'd0, 6'd0);
    chk(status, 8'h00, "R5 wipe done");

    wr('h00, 32'h01);
    retire_n(20);
    rd('h14, 32'h0F, "R8 saturation");
    strobe(1'b1, 1'b0, 5'd0, 6'd0);

    wr('h00, 32'h01);
    strobe(1'b0, 1'b0, 5'd0, 6'b010000);
    chk(status, 8'hFF, "R7 locked");
    chk(a_fatal, 1, "R7 fatal alert");
    rd('h08, 32'h0010_0000, "R7 err fatal bit");
    rd('h10, 32'h10, "R7 cause bit");
    wr('h00, 32'h01);
    chk(status, 8'hFF, "R7 cmd ignored");
    strobe(1'b1, 1'b0, 5'd0, 6'd0);
    chk(status, 8'hFF, "R7 done ignored");
    chk(a_fatal, 1, "R7 alert held");
    rd('h10, 32'h10, "R9 cause kept");

    do_reset();
    chk(status, 8'h00, "R1 unlocked by reset");
    chk(a_fatal, 0, "R1 alert cleared");
    rd('h10, 0, "R9 cause cleared by reset");

    @(negedge clk);
    chk(q.size(), 0, "R11 scoreboard drained");
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule